// File: doc/BRIEF.md
# Sleep and Wake Sequencer

This block controls when a serial peripheral enters and leaves its low-power state. The host must issue the sleep command byte twice, close together in time. The block then answers with an acknowledge byte on its transmit stream. Before it sleeps, it waits for the wake pin to be released (high). If the pin stays low for too long, the block asks for a self-reset instead of sleeping.

While asleep, the data-ready output is held low. A low level on the wake pin that lasts at least a minimum width wakes the device. Shorter glitches are ignored. On wake, data-ready is released and a ready byte is offered to the host. If sync mode is set, the wake pulse also restarts scanning from key 0.

The wake pin is asynchronous and passes through a two-flop synchroniser inside the block. All three time windows (arming, release timeout and minimum wake width) are parameters counted in clock cycles.

The transmit side is a valid/ready stream. The rules for back-pressure are:
- While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- A byte moves on the rising edge where both are high.
- Each byte is offered exactly once.

The command input is a plain strobe with no back-pressure. Commands that arrive while the block is not in its running state are dropped.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset, `tx_valid`=0, `drdy`=1, `asleep`=0, `self_reset`=0 and `scan_restart`=0.
- R2: A second sleep command (byte 0x16) is accepted when it arrives no more than ARM_WIN_CYC cycles after the first one. The block then offers 0xE9 on the transmit stream. A single sleep command produces no output.
- R3: A sleep command arriving more than ARM_WIN_CYC cycles after the arming one is not accepted. It arms the guard afresh, and a later in-window sleep command is then accepted.
- R4: Any command byte other than 0x16 that arrives between the two sleep commands clears the arming, so the second sleep command produces no acknowledge.
- R5: Once offered, a transmit byte keeps `tx_valid` high and `tx_data` unchanged until a cycle with `tx_ready` high. After that handshake the byte is not offered again.
- R6: After the acknowledge is taken, the block stays awake (`asleep`=0, `drdy`=1) while the synchronised wake pin is low. It enters sleep (`asleep`=1, `drdy`=0) within a few cycles of the pin going high.
- R7: If the wake pin stays low for REL_TMO_CYC cycles after the acknowledge handshake, `self_reset` pulses for exactly one cycle. It appears REL_TMO_CYC cycles after the handshake edge. The block then returns to its running state and accepts a new sleep pair.
- R8: While asleep, a low pulse on the wake pin shorter than WAKE_MIN_CYC cycles is ignored. A low pulse of WAKE_MIN_CYC cycles or more wakes the block.
- R9: On wake, `drdy` returns high and the byte 0x01 is offered. After it is taken, the block is running and the arming guard is clear.
- R10: When `sync_mode`=1 at wake, `scan_restart` pulses for one cycle, in the same cycle the 0x01 byte is first offered. When `sync_mode`=0 it stays low.
- R11: Commands that arrive while the acknowledge is pending, while waiting for release, or while asleep are discarded. They change neither the transmit stream nor the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe: a decoded command byte is present this cycle |
| cmd_byte | input | 8 | Command byte that goes with `cmd_valid` |
| wake_pin | input | 1 | Raw asynchronous wake pin, active low |
| sync_mode | input | 1 | When set, a wake also restarts scanning at key 0 |
| tx_ready | input | 1 | Transmit stream ready |
| tx_valid | output | 1 | Transmit stream valid |
| tx_data | output | 8 | Transmit byte (0xE9 acknowledge or 0x01 ready) |
| drdy | output | 1 | Data-ready level, low while asleep |
| asleep | output | 1 | High while the block is in its sleep state |
| self_reset | output | 1 | One-cycle request to reset the device |
| scan_restart | output | 1 | One-cycle request to restart scanning at key 0 |

## Verification
The bench places the second sleep command exactly at the edge of the arming window and one cycle past it. A design with an off-by-one window would acknowledge the late command or refuse the on-time one. It sends wake pulses one cycle shorter than the minimum width and exactly at the minimum width. A miscounting qualifier would then wake on a glitch or sleep through a valid pulse. It holds the wake pin low through the whole release timeout and measures the cycle at which the self-reset appears, which catches a timer that fires early, fires late or never clears. It also stalls the transmit stream and injects commands while the block is busy or asleep, which exposes a design that drops or changes a pending byte, or re-arms while asleep.

// File: rtl/swk_pkg.sv
package swk_pkg;
  localparam logic [7:0] CMD_SLEEP  = 8'h16;
  localparam logic [7:0] BYTE_ACK   = 8'hE9;
  localparam logic [7:0] BYTE_READY = 8'h01;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ACK,
    ST_WAIT_REL,
    ST_SLEEP,
    ST_WAKE
  } swk_state_t;
endpackage

// File: rtl/swk_sync2.sv
module swk_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= d_async;
      s2_q <= s1_q;
    end
  end

  assign q_sync = s2_q;
endmodule

// File: rtl/swk_arm_guard.sv
module swk_arm_guard #(
  parameter int unsigned WIN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic other,
  output logic armed
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!en || other || (hit && armed_q)) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (hit) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (cnt_q == LAST) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign armed = armed_q;

  // R4: a foreign command leaves the guard disarmed
  a_r4_other_clears: assert property (@(posedge clk) disable iff (!rst_n)
    other |=> !armed_q);
  // R2: the window counter never runs past its limit while armed
  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q < CW'(WIN)));
endmodule

// File: rtl/swk_width_qual.sv
module swk_width_qual #(
  parameter int unsigned MINW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pin_s,
  output logic hit
);
  localparam int unsigned CW = $clog2(MINW + 1);
  localparam logic [CW-1:0] LAST = CW'(MINW - 1);

  logic [CW-1:0] cnt_q;

  assign hit = en && !pin_s && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || pin_s) begin
      cnt_q <= '0;
    end else if (!hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8: a running low count implies the pin was low on the previous edge
  a_r8_count_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(!pin_s));
endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
  import swk_pkg::*;
#(
  parameter int unsigned ARM_WIN_CYC  = 1_000_000,
  parameter int unsigned REL_TMO_CYC  = 20_000_000,
  parameter int unsigned WAKE_MIN_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       wake_pin,
  input  logic       sync_mode,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       drdy,
  output logic       asleep,
  output logic       self_reset,
  output logic       scan_restart
);
  localparam int unsigned RW = $clog2(REL_TMO_CYC + 1);
  localparam logic [RW-1:0] REL_LAST = RW'(REL_TMO_CYC - 1);

  swk_state_t    state_q;
  logic [RW-1:0] rel_cnt_q;
  logic          self_reset_q, scan_restart_q;
  logic          wake_s, armed, wake_hit;
  logic          run, g_hit, g_other, accept;

  swk_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (wake_pin),
    .q_sync  (wake_s)
  );

  assign run     = (state_q == ST_RUN);
  assign g_hit   = run && cmd_valid && (cmd_byte == CMD_SLEEP);
  assign g_other = run && cmd_valid && (cmd_byte != CMD_SLEEP);
  assign accept  = g_hit && armed;

  swk_arm_guard #(.WIN(ARM_WIN_CYC)) u_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run),
    .hit   (g_hit),
    .other (g_other),
    .armed (armed)
  );

  swk_width_qual #(.MINW(WAKE_MIN_CYC)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state_q == ST_SLEEP),
    .pin_s (wake_s),
    .hit   (wake_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= ST_RUN;
      rel_cnt_q      <= '0;
      self_reset_q   <= 1'b0;
      scan_restart_q <= 1'b0;
    end else begin
      self_reset_q   <= 1'b0;
      scan_restart_q <= 1'b0;
      unique case (state_q)
        ST_RUN: if (accept) state_q <= ST_ACK;
        ST_ACK: if (tx_ready) begin
          state_q   <= ST_WAIT_REL;
          rel_cnt_q <= '0;
        end
        ST_WAIT_REL: begin
          if (wake_s) begin
            state_q <= ST_SLEEP;
          end else if (rel_cnt_q == REL_LAST) begin
            state_q      <= ST_RUN;
            self_reset_q <= 1'b1;
          end else begin
            rel_cnt_q <= rel_cnt_q + 1'b1;
          end
        end
        ST_SLEEP: if (wake_hit) begin
          state_q        <= ST_WAKE;
          scan_restart_q <= sync_mode;
        end
        ST_WAKE: if (tx_ready) state_q <= ST_RUN;
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign tx_valid     = (state_q == ST_ACK) || (state_q == ST_WAKE);
  assign tx_data      = (state_q == ST_ACK)  ? BYTE_ACK :
                        (state_q == ST_WAKE) ? BYTE_READY : 8'h00;
  assign drdy         = (state_q != ST_SLEEP);
  assign asleep       = (state_q == ST_SLEEP);
  assign self_reset   = self_reset_q;
  assign scan_restart = scan_restart_q;

  // R5: an offered byte holds until taken
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R7: self-reset is a single-cycle pulse
  a_r7_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    self_reset |=> !self_reset);
  // R7: self-reset only follows a low pin while waiting for release
  a_r7_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    self_reset |-> ($past(state_q == ST_WAIT_REL) && $past(!wake_s)));
  // R6: sleep is entered only with the pin released
  a_r6_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(wake_s));
  // R8: leaving sleep happens on a low pin
  a_r8_wake_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(!wake_s));
  // R10: restart pulse coincides with the offered ready byte
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    scan_restart |-> ($past(sync_mode) && tx_valid && tx_data == BYTE_READY));
  // R11: nothing is transmitted while asleep
  a_r11_quiet_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !tx_valid);
endmodule

// File: tb/test_sleep_wake_seq.sv
module test_sleep_wake_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ARM  = 20;
  localparam int REL  = 50;
  localparam int WMIN = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, wake_pin = 1'b1, sync_mode = 1'b0, tx_ready = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic tx_valid, drdy, asleep, self_reset, scan_restart;
  logic [7:0] tx_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_wake_seq #(.ARM_WIN_CYC(ARM), .REL_TMO_CYC(REL), .WAKE_MIN_CYC(WMIN)) i_sleep_wake_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wake_pin(wake_pin), .sync_mode(sync_mode), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .drdy(drdy), .asleep(asleep),
    .self_reset(self_reset), .scan_restart(scan_restart)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ack(input int gap, input bit between);
    return (gap <= ARM) && !between;
  endfunction

  // called at a negedge; returns at the negedge after the command edge
  task automatic send_cmd(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic accept_byte(input logic [7:0] exp, input int stall, input string tag);
    chk(tx_valid && tx_data == exp, tag, tx_data, exp);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(tx_valid && tx_data == exp, "R5 hold under stall", tx_data, exp);
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk(!tx_valid, "R5 byte offered once", tx_valid, 0);
  endtask

  task automatic wake_pulse(input int len, output bit seen, output bit rs);
    seen = 1'b0; rs = 1'b0;
    wake_pin = 1'b0;
    for (int i = 0; i < len + 6; i++) begin
      if (i == len) wake_pin = 1'b1;
      @(negedge clk);
      if (!seen && tx_valid) begin seen = 1'b1; rs = scan_restart; end
    end
  endtask

  task automatic go_sleep(input int stall);
    send_cmd(8'h16); send_cmd(8'h16);
    accept_byte(8'hE9, stall, "R2 acknowledge 0xE9");
    repeat (4) @(negedge clk);
    chk(asleep && !drdy, "R6 asleep with drdy low", {asleep, drdy}, 2'b10);
  endtask

  task automatic wake_up(input bit sm, input int len);
    bit seen, rs;
    sync_mode = sm;
    wake_pulse(len, seen, rs);
    chk(seen, "R8 qualified pulse wakes", seen, 1);
    chk(drdy && !asleep, "R9 drdy released on wake", {asleep, drdy}, 2'b01);
    chk(rs == sm, "R10 scan restart follows sync mode", rs, sm);
    accept_byte(8'h01, 0, "R9 ready byte 0x01");
    chk(!scan_restart, "R10 restart is one pulse", scan_restart, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen, rs;
    int n;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_valid && drdy && !asleep && !self_reset && !scan_restart, "R1 reset state",
        {tx_valid, drdy, asleep, self_reset, scan_restart}, 5'b01000);

    // R2 single command gives nothing
    send_cmd(8'h16);
    repeat (ARM + 5) @(negedge clk);
    chk(!tx_valid, "R2 single sleep command silent", tx_valid, 0);
    send_cmd(8'h0F);

    // R2 second command exactly at window limit
    send_cmd(8'h16); repeat (ARM - 1) @(negedge clk); send_cmd(8'h16);
    chk(tx_valid && tx_data == 8'hE9, "R2 accept at window edge", tx_data, 8'hE9);
    accept_byte(8'hE9, 0, "R2 acknowledge");
    repeat (4) @(negedge clk);
    wake_up(1'b0, WMIN + 2);

    // R3 one cycle late rearms, then in-window one accepted
    send_cmd(8'h16); repeat (ARM) @(negedge clk); send_cmd(8'h16);
    chk(!tx_valid, "R3 late command not accepted", tx_valid, 0);
    repeat (3) @(negedge clk); send_cmd(8'h16);
    chk(tx_valid && tx_data == 8'hE9, "R3 rearmed guard accepts", tx_data, 8'hE9);
    // R11 commands during pending ack discarded, R5 stall
    send_cmd(8'h0F); send_cmd(8'h16);
    chk(tx_valid && tx_data == 8'hE9, "R11 ack unaffected by commands", tx_data, 8'hE9);
    accept_byte(8'hE9, 3, "R5 stalled acknowledge");
    repeat (4) @(negedge clk);
    // R11 commands while asleep
    send_cmd(8'h16); send_cmd(8'h16); send_cmd(8'h0F);
    repeat (2) @(negedge clk);
    chk(asleep && !tx_valid, "R11 commands ignored asleep", {asleep, tx_valid}, 2'b10);
    // R8 short pulse ignored, exact minimum wakes
    wake_pulse(WMIN - 1, seen, rs);
    chk(!seen && asleep, "R8 short pulse ignored", {seen, asleep}, 2'b01);
    wake_up(1'b1, WMIN);

    // R9 guard clear after wake: single command silent
    send_cmd(8'h16);
    repeat (2) @(negedge clk);
    chk(!tx_valid, "R9 guard clear after wake", tx_valid, 0);
    send_cmd(8'h0F);

    // R4 foreign command in between
    send_cmd(8'h16); send_cmd(8'h40); send_cmd(8'h16);
    chk(!tx_valid, "R4 intervening command clears arm", tx_valid, 0);
    send_cmd(8'h0F);

    // R6 wait for release
    wake_pin = 1'b0;
    send_cmd(8'h16); send_cmd(8'h16);
    accept_byte(8'hE9, 0, "R6 acknowledge");
    repeat (10) @(negedge clk);
    chk(!asleep && drdy, "R6 awake while pin low", {asleep, drdy}, 2'b01);
    wake_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk(asleep && !drdy, "R6 sleeps after release", {asleep, drdy}, 2'b10);
    wake_up(1'b0, WMIN + 3);

    // R7 release timeout
    wake_pin = 1'b0;
    send_cmd(8'h16); send_cmd(8'h16);
    accept_byte(8'hE9, 0, "R7 acknowledge");
    n = 0;
    while (!self_reset && n < REL + 10) begin @(negedge clk); n++; end
    chk(n == REL, "R7 self reset timing", n, REL);
    @(negedge clk);
    chk(!self_reset && !asleep && drdy && !tx_valid, "R7 one pulse back to run",
        {self_reset, asleep, drdy, tx_valid}, 4'b0010);
    wake_pin = 1'b1;
    repeat (3) @(negedge clk);
    go_sleep(0);
    wake_up(1'b0, WMIN);

    // random mix against model (R2 R3 R4 R5 R8 R10)
    for (int it = 0; it < 25; it++) begin
      int gap, a;
      bit btw;
      send_cmd(8'h0F);
      gap = 2 + int'($urandom_range(2 * ARM));
      btw = ($urandom_range(3) == 0);
      a = int'($urandom_range(gap - 2));
      send_cmd(8'h16);
      if (btw) begin
        repeat (a) @(negedge clk);
        send_cmd(8'h33);
        repeat (gap - a - 2) @(negedge clk);
      end else begin
        repeat (gap - 1) @(negedge clk);
      end
      send_cmd(8'h16);
      if (exp_ack(gap, btw)) begin
        chk(tx_valid && tx_data == 8'hE9, "R2 random pair accepted", tx_data, 8'hE9);
        accept_byte(8'hE9, int'($urandom_range(3)), "R5 random acknowledge");
        repeat (4) @(negedge clk);
        chk(asleep, "R6 random sleep", asleep, 1);
        wake_up(1'(int'($urandom_range(1))), WMIN + int'($urandom_range(5)));
      end else begin
        chk(!tx_valid, "R3 R4 random pair refused", tx_valid, 0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule